// File: doc/BRIEF.md
# Stack Device Command Handler

This block sits on a device in a daisy-chained stack and acts on commands that the link layer has already framed and checked. Each command is given to it for one cycle as an opcode, a target stack address and a small payload. The block keeps the device's stack address, the stack size and the balance-enable bit. It decides whether the device must answer with a response frame, and it pulses a register-reset output when the device receives a reset that is meant for it.

Reset acts only on the device's own address and is ignored on the all-devices address. The two balancing commands act on both the device's own address and the all-devices address. Identify loads the address and the stack size, and in this block it is accepted whatever the target address is. The balance-enable bit can also be written directly through a setup-register write port. An accepted command takes priority over that write when both arrive in the same cycle.

Top module: `stk_cmd_handler`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `stack_addr`, `stack_size`, `bal_en`, `rsp_req` and `reg_rst_pulse` are all zero.
- R2: Identify (opcode 1) is accepted on any target address. One cycle later `stack_addr` equals payload bits [3:0] and `stack_size` equals payload bits [7:4], and `rsp_req` is high for one cycle.
- R3: Reset (opcode 2) sent to the device's own address, when that address is not all ones, clears `stack_addr`, `stack_size` and `bal_en` one cycle later. In that same cycle `reg_rst_pulse` is high and `rsp_req` stays low.
- R4: Reset sent to the all-devices address (4'hF) does nothing: no pulse, no response and no change of state. This holds even when the device's own address is 4'hF.
- R5: Balance Enable (opcode 3) sent to the device's own address or to 4'hF sets `bal_en` one cycle later, and `rsp_req` is high for one cycle.
- R6: Balance Inhibit (opcode 4) sent to the device's own address or to 4'hF clears `bal_en` one cycle later, and `rsp_req` is high for one cycle.
- R7: A Reset, Balance Enable or Balance Inhibit whose address is neither the device's own address nor 4'hF changes no state and produces no response or pulse.
- R8: A setup write (`setup_wr` high) in a cycle with no accepted Reset or balance command loads `bal_en` from `setup_ben` one cycle later, with no response.
- R9: When an accepted Reset or balance command and a setup write fall in the same cycle, the command decides `bal_en` and the write is dropped.
- R10: Opcodes 0, 5, 6 and 7 are ignored: no state change, no response, no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A framed command is present this cycle |
| cmd_op | input | 3 | Command opcode |
| cmd_addr | input | 4 | Target stack address; all ones addresses all devices |
| cmd_data | input | 8 | Payload: [3:0] new address, [7:4] stack size (Identify only) |
| setup_wr | input | 1 | Direct write strobe to the balance setup register |
| setup_ben | input | 1 | Balance-enable value carried by the setup write |
| stack_addr | output | 4 | Device's programmed stack address |
| stack_size | output | 4 | Programmed stack size |
| bal_en | output | 1 | Balance-enable bit |
| rsp_req | output | 1 | One-cycle request to send a response frame |
| reg_rst_pulse | output | 1 | One-cycle pulse that returns device registers to power-up values |

## Verification
A command and a direct setup write can both target the balance-enable bit in the same cycle. The vector table drives a balance command or an addressed Reset together with a setup write that carries the opposite value. The result is judged by checking that `bal_en` follows the command one cycle later. A second conflict is the address rule for Reset: the table programs the device to address 4'hF through Identify and then sends Reset to 4'hF. The check passes only if the all-devices rule wins, so no pulse appears and the state is kept.

// File: rtl/stk_cmd_pkg.sv
// Package: opcodes and decoded-command type shared by the command handler.
package stk_cmd_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OPC_NOP     = 3'd0,
        OPC_IDENT   = 3'd1,
        OPC_RESET   = 3'd2,
        OPC_BAL_ON  = 3'd3,
        OPC_BAL_OFF = 3'd4
    } opcode_e;

    typedef struct packed {
        logic ident;
        logic reset;
        logic bal_on;
        logic bal_off;
    } cmd_hit_t;

endpackage

// File: rtl/stk_cmd_decode.sv
// Module: stk_cmd_decode
// Classifies one framed command into accepted actions using the address rules.
// Assumes: the command is valid for exactly one cycle; all-ones is broadcast.
module stk_cmd_decode
    import stk_cmd_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                  cmd_valid,
    input  logic [OP_W-1:0]       cmd_op,
    input  logic [ADDR_W-1:0]     cmd_addr,
    input  logic [ADDR_W-1:0]     own_addr,
    output cmd_hit_t              hit
);
    localparam logic [ADDR_W-1:0] BCAST = '1;

    logic is_bcast;
    logic is_own;

    // Purpose: address match and per-opcode acceptance.
    always_comb begin
        is_bcast    = (cmd_addr == BCAST);
        is_own      = (cmd_addr == own_addr);
        hit.ident   = cmd_valid && (cmd_op == OPC_IDENT);
        hit.reset   = cmd_valid && (cmd_op == OPC_RESET) && is_own && !is_bcast;
        hit.bal_on  = cmd_valid && (cmd_op == OPC_BAL_ON) && (is_own || is_bcast);
        hit.bal_off = cmd_valid && (cmd_op == OPC_BAL_OFF) && (is_own || is_bcast);
    end
endmodule

// File: rtl/stk_id_regs.sv
// Module: stk_id_regs
// Holds the stack address and stack size; Identify loads, Reset clears.
// Assumes: payload low field is the address, high field the size.
module stk_id_regs
    import stk_cmd_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int SIZE_W = 4,
    localparam int DATA_W = ADDR_W + SIZE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_hit_t          hit,
    input  logic [DATA_W-1:0] payload,
    output logic [ADDR_W-1:0] stack_addr,
    output logic [SIZE_W-1:0] stack_size
);
    // Purpose: update identity registers; reset command has priority.
    always_ff @(posedge clk) begin
        if (!rst_n || hit.reset) begin
            stack_addr <= '0;
            stack_size <= '0;
        end else if (hit.ident) begin
            stack_addr <= payload[ADDR_W-1:0];
            stack_size <= payload[DATA_W-1:ADDR_W];
        end
    end
endmodule

// File: rtl/stk_bal_ctrl.sv
// Module: stk_bal_ctrl
// Owns the balance-enable bit. Priority: reset, enable, inhibit, setup write.
// Assumes: enable and inhibit never both hit in one cycle (distinct opcodes).
module stk_bal_ctrl
    import stk_cmd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  cmd_hit_t hit,
    input  logic     setup_wr,
    input  logic     setup_ben,
    output logic     bal_en
);
    // Purpose: resolve commands against the direct register write.
    always_ff @(posedge clk) begin
        if (!rst_n || hit.reset) begin
            bal_en <= 1'b0;
        end else if (hit.bal_on) begin
            bal_en <= 1'b1;
        end else if (hit.bal_off) begin
            bal_en <= 1'b0;
        end else if (setup_wr) begin
            bal_en <= setup_ben;
        end
    end
endmodule

// File: rtl/stk_rsp_gen.sv
// Module: stk_rsp_gen
// Registers the one-cycle response request and register-reset pulse.
// Assumes: reset never answers; other accepted commands always answer.
module stk_rsp_gen
    import stk_cmd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  cmd_hit_t hit,
    output logic     rsp_req,
    output logic     reg_rst_pulse
);
    // Purpose: produce single-cycle outputs from this cycle's accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_req       <= 1'b0;
            reg_rst_pulse <= 1'b0;
        end else begin
            rsp_req       <= hit.ident || hit.bal_on || hit.bal_off;
            reg_rst_pulse <= hit.reset;
        end
    end
endmodule

// File: rtl/stk_cmd_handler.sv
// Module: stk_cmd_handler (top)
// Device-side command handler for a daisy-chained stack: decodes Identify,
// Reset and balance commands, keeps identity and balance-enable state.
// Assumes: commands are already framed and CRC-checked upstream.
module stk_cmd_handler
    import stk_cmd_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int SIZE_W = 4,
    localparam int DATA_W = ADDR_W + SIZE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [OP_W-1:0]   cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              setup_wr,
    input  logic              setup_ben,
    output logic [ADDR_W-1:0] stack_addr,
    output logic [SIZE_W-1:0] stack_size,
    output logic              bal_en,
    output logic              rsp_req,
    output logic              reg_rst_pulse
);
    cmd_hit_t hit;

    stk_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .own_addr  (stack_addr),
        .hit       (hit)
    );

    stk_id_regs #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_id (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit        (hit),
        .payload    (cmd_data),
        .stack_addr (stack_addr),
        .stack_size (stack_size)
    );

    stk_bal_ctrl u_bal (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (hit),
        .setup_wr  (setup_wr),
        .setup_ben (setup_ben),
        .bal_en    (bal_en)
    );

    stk_rsp_gen u_rsp (
        .clk           (clk),
        .rst_n         (rst_n),
        .hit           (hit),
        .rsp_req       (rsp_req),
        .reg_rst_pulse (reg_rst_pulse)
    );
endmodule

// File: rtl/stk_cmd_handler_chk.sv
// Module: stk_cmd_handler_chk
// Port-level properties of the command handler, bound to the top module.
module stk_cmd_handler_chk
    import stk_cmd_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int SIZE_W = 4,
    localparam int DATA_W = ADDR_W + SIZE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [OP_W-1:0]   cmd_op,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic [DATA_W-1:0] cmd_data,
    input logic              setup_wr,
    input logic              setup_ben,
    input logic [ADDR_W-1:0] stack_addr,
    input logic [SIZE_W-1:0] stack_size,
    input logic              bal_en,
    input logic              rsp_req,
    input logic              reg_rst_pulse
);
    localparam logic [ADDR_W-1:0] BCAST = '1;

    p_ident_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_op == OPC_IDENT |=>
            stack_addr == $past(cmd_data[ADDR_W-1:0]) && rsp_req);

    p_rst_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rst_pulse |-> !rsp_req && stack_addr == '0 && stack_size == '0 && !bal_en);

    p_bcast_reset_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_op == OPC_RESET && cmd_addr == BCAST |=>
            !reg_rst_pulse && $stable(stack_addr) && $stable(stack_size));

    p_bal_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_op == OPC_BAL_ON && (cmd_addr == stack_addr || cmd_addr == BCAST)
            |=> bal_en && rsp_req);

    p_bal_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_op == OPC_BAL_OFF && (cmd_addr == stack_addr || cmd_addr == BCAST)
            |=> !bal_en && rsp_req);

    p_foreign_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_op != OPC_IDENT && cmd_addr != stack_addr && cmd_addr != BCAST
            && !setup_wr |=> $stable(bal_en) && !rsp_req && !reg_rst_pulse);

    p_setup_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        setup_wr && !cmd_valid |=> bal_en == $past(setup_ben) && !rsp_req);

    p_unknown_op_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_op > OPC_BAL_OFF && !setup_wr |=>
            $stable(bal_en) && $stable(stack_addr) && !rsp_req && !reg_rst_pulse);
endmodule

bind stk_cmd_handler stk_cmd_handler_chk #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_op        (cmd_op),
    .cmd_addr      (cmd_addr),
    .cmd_data      (cmd_data),
    .setup_wr      (setup_wr),
    .setup_ben     (setup_ben),
    .stack_addr    (stack_addr),
    .stack_size    (stack_size),
    .bal_en        (bal_en),
    .rsp_req       (rsp_req),
    .reg_rst_pulse (reg_rst_pulse)
);

// File: tb/test_stk_cmd_handler.sv
// Bench: vector table walked by one loop, then directed reset checks.
module test_stk_cmd_handler;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NV = 21;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = '0;
    logic [3:0] cmd_addr = '0;
    logic [7:0] cmd_data = '0;
    logic       setup_wr = 1'b0;
    logic       setup_ben = 1'b0;
    logic [3:0] stack_addr;
    logic [3:0] stack_size;
    logic       bal_en;
    logic       rsp_req;
    logic       reg_rst_pulse;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stk_cmd_handler i_stk_cmd_handler (.*);

    // Fields: req[32:29] valid[28] op[27:25] addr[24:21] data[20:13] wr[12] wben[11]
    //         exp_addr[10:7] exp_size[6:3] exp_ben[2] exp_rsp[1] exp_rst[0]
    localparam logic [32:0] VEC [NV] = '{
        {4'd2, 1'b1,3'd1,4'h0,8'h35,1'b0,1'b0, 4'h5,4'h3,1'b0,1'b1,1'b0}, // R2 identify
        {4'd5, 1'b1,3'd3,4'h5,8'h00,1'b0,1'b0, 4'h5,4'h3,1'b1,1'b1,1'b0}, // R5 own
        {4'd6, 1'b1,3'd4,4'hF,8'h00,1'b0,1'b0, 4'h5,4'h3,1'b0,1'b1,1'b0}, // R6 broadcast
        {4'd5, 1'b1,3'd3,4'hF,8'h00,1'b0,1'b0, 4'h5,4'h3,1'b1,1'b1,1'b0}, // R5 broadcast
        {4'd4, 1'b1,3'd2,4'hF,8'h00,1'b0,1'b0, 4'h5,4'h3,1'b1,1'b0,1'b0}, // R4
        {4'd7, 1'b1,3'd4,4'h7,8'h00,1'b0,1'b0, 4'h5,4'h3,1'b1,1'b0,1'b0}, // R7 inhibit
        {4'd7, 1'b1,3'd2,4'h7,8'h00,1'b0,1'b0, 4'h5,4'h3,1'b1,1'b0,1'b0}, // R7 reset
        {4'd10,1'b1,3'd0,4'h5,8'h00,1'b0,1'b0, 4'h5,4'h3,1'b1,1'b0,1'b0}, // R10 op 0
        {4'd10,1'b1,3'd7,4'h5,8'h00,1'b0,1'b0, 4'h5,4'h3,1'b1,1'b0,1'b0}, // R10 op 7
        {4'd8, 1'b0,3'd0,4'h0,8'h00,1'b1,1'b0, 4'h5,4'h3,1'b0,1'b0,1'b0}, // R8 write 0
        {4'd8, 1'b0,3'd0,4'h0,8'h00,1'b1,1'b1, 4'h5,4'h3,1'b1,1'b0,1'b0}, // R8 write 1
        {4'd9, 1'b1,3'd4,4'h5,8'h00,1'b1,1'b1, 4'h5,4'h3,1'b0,1'b1,1'b0}, // R9 inhibit wins
        {4'd9, 1'b1,3'd3,4'h5,8'h00,1'b1,1'b0, 4'h5,4'h3,1'b1,1'b1,1'b0}, // R9 enable wins
        {4'd3, 1'b1,3'd2,4'h5,8'h00,1'b1,1'b1, 4'h0,4'h0,1'b0,1'b0,1'b1}, // R3 + R9
        {4'd3, 1'b0,3'd0,4'h0,8'h00,1'b0,1'b0, 4'h0,4'h0,1'b0,1'b0,1'b0}, // R3 pulse ends
        {4'd7, 1'b1,3'd3,4'h5,8'h00,1'b0,1'b0, 4'h0,4'h0,1'b0,1'b0,1'b0}, // R7 old addr
        {4'd5, 1'b1,3'd3,4'h0,8'h00,1'b0,1'b0, 4'h0,4'h0,1'b1,1'b1,1'b0}, // R5 addr 0
        {4'd2, 1'b1,3'd1,4'h3,8'hEF,1'b0,1'b0, 4'hF,4'hE,1'b1,1'b1,1'b0}, // R2 to F
        {4'd4, 1'b1,3'd2,4'hF,8'h00,1'b0,1'b0, 4'hF,4'hE,1'b1,1'b0,1'b0}, // R4 own=F
        {4'd2, 1'b1,3'd1,4'hF,8'h12,1'b0,1'b0, 4'h2,4'h1,1'b1,1'b1,1'b0}, // R2 bcast target
        {4'd3, 1'b1,3'd2,4'h2,8'h00,1'b0,1'b0, 4'h0,4'h0,1'b0,1'b0,1'b1}  // R3
    };

    task automatic chk(input int req, input string what, input logic [7:0] act,
                       input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input int req, input logic [3:0] ea, input logic [3:0] es,
                           input logic eb, input logic er, input logic ep);
        chk(req, "stack_addr", {4'h0, stack_addr}, {4'h0, ea});
        chk(req, "stack_size", {4'h0, stack_size}, {4'h0, es});
        chk(req, "bal_en", {7'h0, bal_en}, {7'h0, eb});
        chk(req, "rsp_req", {7'h0, rsp_req}, {7'h0, er});
        chk(req, "reg_rst_pulse", {7'h0, reg_rst_pulse}, {7'h0, ep});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk_all(1, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0); // R1 during reset
        rst_n = 1'b1;
        @(negedge clk);
        chk_all(1, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0); // R1 first cycle after release
        for (int i = 0; i < NV; i++) begin
            cmd_valid = VEC[i][28];
            cmd_op    = VEC[i][27:25];
            cmd_addr  = VEC[i][24:21];
            cmd_data  = VEC[i][20:13];
            setup_wr  = VEC[i][12];
            setup_ben = VEC[i][11];
            @(negedge clk);
            cmd_valid = 1'b0;
            setup_wr  = 1'b0;
            chk_all(int'(VEC[i][32:29]), VEC[i][10:7], VEC[i][6:3], VEC[i][2],
                    VEC[i][1], VEC[i][0]);
        end
        // R1: load state, then assert reset with a command present; it must clear.
        cmd_valid = 1'b1; cmd_op = 3'd1; cmd_addr = 4'h0; cmd_data = 8'h9A;
        @(negedge clk);
        cmd_op = 3'd3; cmd_addr = 4'hA;
        @(negedge clk);
        chk_all(5, 4'hA, 4'h9, 1'b1, 1'b1, 1'b0); // R5 after identify
        rst_n = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk_all(1, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0); // R1 mid-run reset
        rst_n = 1'b1;
        @(negedge clk);
        chk_all(1, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0); // R1 idle after release
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule